// File: doc/BRIEF.md
# Serial Frame Receiver with Line Watchdogs

This block sits behind a clock-recovery and line-decoding stage. It takes one decoded bit per strobe, plus a flag that marks a line-coding violation, and turns the stream into bytes and frame events. It first hunts for an alternating lead-in. Repeaters may shorten that lead-in, so four alternating bits are enough for the block to lock. It then waits for a 16-bit start pattern. After that it shifts data in most significant bit first and issues one pulse per byte, together with the position of that byte in the frame.

A frame closes on a 16-bit end pattern. The block accepts that pattern only when it lines up with a byte boundary. The bytes between the start and end patterns feed a running CRC-16, and the frame closes with exactly one pulse: good or bad. Each byte is released one byte time after it arrives. This lets the block recognise the end pattern and keep it out of both the byte stream and the CRC.

Two recovery paths do not depend on line traffic. First, every non-idle state has its own timeout counted in system clocks. Second, a detector forces the receiver back to idle when the line level stops changing for too long. Together they make sure the receiver waits in idle before the next frame.

Top module: `frame_rx`

## Requirements
- R1: During and right after reset, `byte_rdy_o`, `frame_ok_o` and `frame_bad_o` are low and `byte_o` is zero.
- R2: The receiver locks after at least `PRE_MIN` (default 4) strobed bits that alternate consecutively, starting from idle, and it then starts data only after the 16-bit `START_PAT` (default 16'hE38E, sent MSB first). With three alternating bits and no further alternation run, no frame is received.
- R3: Data bits are packed MSB first. Each byte appears on `byte_o` with a one-cycle `byte_rdy_o` pulse, the cycle after a strobe. `byte_idx_o` starts at 0 after each start pattern and rises by one per byte.
- R4: The CRC is CRC-16 with polynomial 0x1021, preset 16'hFFFF, MSB first. It covers every byte between the start and end patterns. When the register equals `CRC_RESIDUE` (default 0, which results from appending the CRC high byte first), the frame closes with `frame_ok_o`.
- R5: A frame whose CRC residue differs from `CRC_RESIDUE` closes with `frame_bad_o`.
- R6: The 16-bit `END_PAT` (default 16'hF0C7) closes a frame only when it completes on a byte boundary. A match that completes at any other bit position closes the frame with `frame_bad_o`, so a frame with one dropped bit is rejected.
- R7: A closed frame gives exactly one of `frame_ok_o` and `frame_bad_o`, as a one-cycle pulse the cycle after a strobe. It never coincides with `byte_rdy_o`, and the end-pattern bytes never appear as data.
- R8: A strobed bit with `code_err_i` high inside the data field closes the frame at once with `frame_bad_o`. Bytes that were not yet released are dropped, and the next frame is received normally.
- R9: When a non-idle state lasts `TIMEOUT` clocks, the receiver returns to idle with no frame pulse, even while strobes keep arriving.
- R10: When the strobed bit value does not change for `IDLE_LIM` clocks, the receiver returns to idle with no frame pulse. Bits that follow are not taken as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Decoded bit value, valid with the strobe |
| bit_stb_i | input | 1 | One-cycle strobe per received bit |
| code_err_i | input | 1 | Line-coding violation on the strobed bit |
| byte_o | output | 8 | Received byte, MSB first on the line |
| byte_rdy_o | output | 1 | One-cycle pulse, `byte_o` is valid |
| byte_idx_o | output | IDXW | Position of `byte_o` in the frame, from 0 |
| frame_ok_o | output | 1 | Frame closed with good CRC and coding |
| frame_bad_o | output | 1 | Frame closed with an error |

## Verification
The assertions check several things on every cycle. The two frame pulses are exclusive of each other and of the byte pulse. Every pulse follows a bit strobe, a good-frame pulse never repeats on the next cycle, and a line that stays quiet past the idle limit always leaves the state machine in idle. Other behaviours are only visible over whole frames, so the bench scenarios cover them. These are preamble length at the lock threshold, byte order and indices, the CRC verdict, rejection of a misaligned end pattern, and the abort on a coding violation. The bench also shows that the timeout and the idle detector stop bytes and frame pulses, which can only be seen over hundreds of clocks of stimulus.

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter logic [15:0] START_PAT   = 16'hE38E,
  parameter logic [15:0] END_PAT     = 16'hF0C7,
  parameter logic [15:0] CRC_RESIDUE = 16'h0000,
  parameter int          PRE_MIN     = 4,
  parameter int          TIMEOUT     = 100000,
  parameter int          IDLE_LIM    = 20000,
  parameter int          IDXW        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_i,
  input  logic            bit_stb_i,
  input  logic            code_err_i,
  output logic [7:0]      byte_o,
  output logic            byte_rdy_o,
  output logic [IDXW-1:0] byte_idx_o,
  output logic            frame_ok_o,
  output logic            frame_bad_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int IW = $clog2(IDLE_LIM + 1);
  localparam int AW = $clog2(PRE_MIN + 1);

  typedef enum logic [1:0] {S_IDLE, S_SYNC, S_DATA} st_t;

  st_t            st;
  logic [14:0]    sh;
  logic           lastb, have1;
  logic [AW-1:0]  alt;
  logic [2:0]     bcnt;
  logic [15:0]    crc;
  logic [TW-1:0]  tcnt;
  logic [IW-1:0]  icnt;
  logic [IDXW-1:0] idx;

  wire [15:0] shn  = {sh, bit_i};
  wire        bnd  = (bcnt == 3'd7);
  wire        efd  = (shn == END_PAT);
  wire        tmo  = (tcnt == TW'(TIMEOUT - 1));
  wire        idl  = (icnt == IW'(IDLE_LIM - 1));
  wire        edge_seen = bit_stb_i && (bit_i != lastb);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 7; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; lastb <= 1'b0; have1 <= 1'b0; alt <= '0;
      bcnt <= '0; crc <= 16'hFFFF; tcnt <= '0; icnt <= '0; idx <= '0;
      byte_o <= '0; byte_rdy_o <= 1'b0; byte_idx_o <= '0;
      frame_ok_o <= 1'b0; frame_bad_o <= 1'b0;
    end else begin
      byte_rdy_o  <= 1'b0;
      frame_ok_o  <= 1'b0;
      frame_bad_o <= 1'b0;
      if (bit_stb_i) begin
        sh    <= shn[14:0];
        lastb <= bit_i;
      end
      if (st == S_IDLE || edge_seen) icnt <= '0;
      else                           icnt <= icnt + IW'(1);
      tcnt <= tcnt + TW'(1);

      case (st)
        S_IDLE: begin
          tcnt <= '0;
          if (bit_stb_i) begin
            if (alt == '0 || bit_i == lastb) alt <= AW'(1);
            else if (alt == AW'(PRE_MIN - 1)) begin
              alt <= '0;
              st  <= S_SYNC;
            end else alt <= alt + AW'(1);
          end
        end
        S_SYNC: begin
          alt <= '0;
          if (bit_stb_i && shn == START_PAT) begin
            st <= S_DATA; tcnt <= '0; bcnt <= '0; have1 <= 1'b0;
            crc <= 16'hFFFF; idx <= '0;
          end
        end
        S_DATA: begin
          alt <= '0;
          if (bit_stb_i) begin
            bcnt <= bcnt + 3'd1;
            if (code_err_i) begin
              frame_bad_o <= 1'b1; st <= S_IDLE;
            end else if (have1 && efd) begin
              frame_ok_o  <= bnd && (crc == CRC_RESIDUE);
              frame_bad_o <= !(bnd && (crc == CRC_RESIDUE));
              st <= S_IDLE;
            end else if (bnd) begin
              have1 <= 1'b1;
              if (have1) begin
                byte_o     <= shn[15:8];
                byte_rdy_o <= 1'b1;
                byte_idx_o <= idx;
                idx        <= idx + IDXW'(1);
                crc        <= crc_step(crc, shn[15:8]);
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase

      if (st != S_IDLE && (tmo || idl)) st <= S_IDLE;
    end
  end
endmodule

// File: rtl/frame_rx_chk.sv
module frame_rx_chk #(
  parameter int IDLE_LIM = 20000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_i,
  input logic       bit_stb_i,
  input logic       byte_rdy_o,
  input logic       frame_ok_o,
  input logic       frame_bad_o,
  input logic [1:0] st
);
  int   qc;
  logic lb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qc <= 0; lb <= 1'b0;
    end else begin
      if (bit_stb_i) lb <= bit_i;
      if (bit_stb_i && bit_i != lb) qc <= 0;
      else if (qc <= IDLE_LIM + 2)  qc <= qc + 1;
    end
  end

  AST_SINGLE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok_o && frame_bad_o)); // R7
  AST_END_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_rdy_o && (frame_ok_o || frame_bad_o))); // R7
  AST_END_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok_o || frame_bad_o) |-> $past(bit_stb_i)); // R7
  AST_BYTE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rdy_o |-> $past(bit_stb_i)); // R3
  AST_OK_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o |=> !frame_ok_o); // R4
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (qc > IDLE_LIM + 1) |-> (st == 2'd0)); // R10
endmodule

bind frame_rx frame_rx_chk #(.IDLE_LIM(IDLE_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_stb_i(bit_stb_i),
  .byte_rdy_o(byte_rdy_o), .frame_ok_o(frame_ok_o), .frame_bad_o(frame_bad_o),
  .st(st)
);

// File: tb/sim_frame_rx.sv
module sim_frame_rx;
  localparam logic [15:0] SP = 16'hE38E;
  localparam logic [15:0] EP = 16'hF0C7;
  // [39:36] preamble bits, [35:32] 1 = corrupt CRC, [31:0] payload
  localparam logic [39:0] VEC [0:5] = '{
    {4'd4, 4'd0, 32'h01234567},
    {4'd8, 4'd1, 32'hDEADBEEF},
    {4'd5, 4'd0, 32'h00000000},
    {4'd6, 4'd0, 32'hFFFFFFFF},
    {4'd7, 4'd1, 32'hA55A3CC3},
    {4'd4, 4'd0, 32'h13579BDF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_i = 1'b0, bit_stb_i = 1'b0, code_err_i = 1'b0;
  logic [7:0] byte_o, byte_idx_o;
  logic byte_rdy_o, frame_ok_o, frame_bad_o;

  always #5 clk = ~clk;

  frame_rx #(.TIMEOUT(2000), .IDLE_LIM(500)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_stb_i(bit_stb_i),
    .code_err_i(code_err_i), .byte_o(byte_o), .byte_rdy_o(byte_rdy_o),
    .byte_idx_o(byte_idx_o), .frame_ok_o(frame_ok_o), .frame_bad_o(frame_bad_o)
  );

  int nvec = 0, nfail = 0, nrx = 0, nok = 0, nbad = 0, fn = 0;
  logic [7:0] rx [0:127];
  logic [7:0] rxi [0:127];
  logic [7:0] fb [0:15];

  always @(negedge clk) if (rst_n) begin
    if (byte_rdy_o) begin
      if (nrx < 128) begin rx[nrx] = byte_o; rxi[nrx] = byte_idx_o; end
      nrx++;
    end
    if (frame_ok_o)  nok++;
    if (frame_bad_o) nbad++;
  end

  task automatic chk(input logic cond, input string req, input int act, input int exp);
    nvec++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    nrx = 0; nok = 0; nbad = 0;
  endtask

  function automatic logic [15:0] crc16(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 7; j >= 0; j--) begin
        logic fbk = c[15] ^ fb[k][j];
        c = c << 1;
        if (fbk) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic load4(input logic [31:0] p, input logic flip);
    logic [15:0] c;
    fb[0] = p[31:24]; fb[1] = p[23:16]; fb[2] = p[15:8]; fb[3] = p[7:0];
    c = crc16(4);
    fb[4] = c[15:8] ^ {7'd0, flip};
    fb[5] = c[7:0];
    fn = 6;
  endtask

  task automatic sb(input logic b, input logic e);
    @(negedge clk); bit_i = b; code_err_i = e; bit_stb_i = 1'b1;
    @(negedge clk); bit_stb_i = 1'b0; code_err_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_head(input int pre);
    for (int i = 0; i < pre; i++) sb((i % 2) == 0, 1'b0);
    for (int i = 15; i >= 0; i--) sb(SP[i], 1'b0);
  endtask

  task automatic send_frame(input int pre, input int drop_at, input int err_at);
    int g = 0;
    send_head(pre);
    for (int k = 0; k < fn; k++)
      for (int j = 7; j >= 0; j--) begin
        if (g != drop_at) sb(fb[k][j], g == err_at);
        g++;
      end
    for (int i = 15; i >= 0; i--) sb(EP[i], 1'b0);
    repeat (20) @(negedge clk);
  endtask

  task automatic gap();
    repeat (600) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d (cycles, run end)", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(byte_rdy_o == 0 && frame_ok_o == 0 && frame_bad_o == 0 && byte_o == 0,
        "R1 reset outputs", int'(byte_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(byte_rdy_o == 0 && frame_ok_o == 0 && frame_bad_o == 0,
        "R1 after release", int'(frame_ok_o) + int'(frame_bad_o), 0);

    foreach (VEC[v]) begin
      logic bad_crc;
      int mism;
      bad_crc = VEC[v][32];
      load4(VEC[v][31:0], bad_crc);
      clr();
      send_frame(int'(VEC[v][39:36]), -1, -1);
      mism = 0;
      for (int i = 0; i < 6 && i < nrx; i++)
        if (rx[i] != fb[i] || rxi[i] != i[7:0]) mism++;
      chk(nrx == 6 && mism == 0, "R3 bytes and index", nrx * 100 + mism, 600);
      if (bad_crc) chk(nbad == 1 && nok == 0, "R5 crc error", nok * 10 + nbad, 1);
      else         chk(nok == 1 && nbad == 0, "R4 crc good", nok * 10 + nbad, 10);
      chk(nok + nbad == 1, "R7 one end pulse", nok + nbad, 1);
      gap();
    end

    load4(32'h0F1E2D3C, 1'b0);
    clr(); send_frame(3, -1, -1);
    chk(nrx == 0 && nok + nbad == 0, "R2 three-bit preamble", nrx + nok + nbad, 0);
    gap();
    clr(); send_frame(4, -1, -1);
    chk(nok == 1 && nrx == 6, "R2 four-bit preamble", nok * 10 + nrx, 16);
    gap();

    clr(); send_frame(8, 10, -1);
    chk(nbad == 1 && nok == 0, "R6 dropped bit", nok * 10 + nbad, 1);
    gap();

    clr(); send_frame(8, -1, 12);
    chk(nbad == 1 && nok == 0, "R8 coding violation", nok * 10 + nbad, 1);
    chk(nrx == 0, "R8 no bytes released", nrx, 0);
    gap();
    clr(); send_frame(8, -1, -1);
    chk(nok == 1 && nbad == 0, "R8 next frame ok", nok * 10 + nbad, 10);
    gap();

    clr();
    send_head(8);
    for (int j = 7; j >= 0; j--) sb(fb[0][j], 1'b0);
    for (int j = 7; j >= 0; j--) sb(fb[1][j], 1'b0);
    repeat (20) @(negedge clk);
    chk(nrx == 1, "R10 bytes before pause", nrx, 1);
    gap();
    clr();
    for (int k = 2; k < fn; k++)
      for (int j = 7; j >= 0; j--) sb(fb[k][j], 1'b0);
    for (int i = 15; i >= 0; i--) sb(EP[i], 1'b0);
    repeat (20) @(negedge clk);
    chk(nrx == 0 && nok + nbad == 0, "R10 idle line resets", nrx + nok + nbad, 0);
    gap();

    clr();
    send_head(8);
    for (int i = 0; i < 700; i++) sb((i % 2) == 0, 1'b0);
    repeat (20) @(negedge clk);
    chk(nrx >= 55 && nrx <= 63, "R9 timeout stops bytes", nrx, 61);
    chk(nok + nbad == 0, "R9 no end pulse", nok + nbad, 0);
    gap();
    clr(); send_frame(5, -1, -1);
    chk(nok == 1 && nrx == 6, "R9 recovery frame", nok * 10 + nrx, 16);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule